// File: doc/BRIEF.md
# Capacitive Touch Scan Sequencer

This block runs capacitive-sensing measurements over a table of eight scan descriptors. Each descriptor holds an enable bit, a transmit index range, a receive index range and a compare threshold. Once armed, the sequencer waits for a trigger. The trigger comes either from a self-clearing software bit or from an external event pulse, depending on a select code. On that trigger it walks the enabled descriptors in ascending index order. For each transmit/receive pair it asks an external measurement unit for one conversion through a start/done handshake, and only one conversion is in flight at a time.

Each completed conversion is forwarded on a results port. The result carries the descriptor number, the two indices and a flag that tells whether the value is above the descriptor's threshold. The nesting of the two index loops is chosen at run time. An abort request ends only the descriptor in progress and the pass moves on. Clearing the enable bit ends the whole pass once the outstanding conversion has returned.

Software programs the block through a word-wide write port. Address 0 is the control word: bit 0 enable, bit 1 order, bit 2 table-write-enable, bit 3 abort, bit 4 software trigger, bits 11:8 trigger select. Addresses 8 to 15 are descriptors 0 to 7, with bit 0 enable, bits 7:4 TX first, bits 11:8 TX last, bits 15:12 RX first, bits 19:16 RX last and bits 31:20 threshold. Writing the control word replaces all of its fields, including the abort bit.

Top module: `tscan_top`

## Requirements
- R1: After reset, busy, desc_done, meas_start, res_valid and ctl_rdata are all 0. Setting the enable bit alone starts no measurement. A pass starts only when a trigger is accepted while the block is enabled and idle, and busy is high from the acceptance until the return to idle.
- R2: Trigger select 0 uses the software-trigger bit and select 1 uses the evt_trig input. Select codes 2 to 15 never start a pass.
- R3: The software-trigger bit (ctl_rdata bit 4) reads 1 for exactly one cycle after it is written and 0 after that.
- R4: With order bit 0, every RX index is scanned for the current TX index before the TX index advances. Both indices count upward.
- R5: With order bit 1, every TX index is scanned for the current RX index before the RX index advances.
- R6: A range whose last index is below its first index scans only the first index.
- R7: Descriptors with the enable bit clear are skipped, and enabled descriptors are visited in ascending index order.
- R8: Descriptor writes are ignored while the table-write-enable bit is 0.
- R9: Writing abort during a descriptor discards that descriptor's outstanding result and continues with the next enabled descriptor, or goes idle if none is left. The abort bit (ctl_rdata bit 3) then reads 0.
- R10: Clearing the enable bit during a pass keeps busy high until the outstanding conversion returns. The block then goes idle without forwarding that result.
- R11: A trigger that arrives while a pass is in progress is ignored.
- R12: desc_done bit i is set when descriptor i completes or is aborted. All bits are cleared when a trigger is accepted.
- R13: Each result carries the descriptor number, TX index, RX index and raw value. res_over is 1 only when the value is strictly greater than the descriptor's threshold.
- R14: meas_start is a single-cycle pulse, and there is at most one outstanding conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: 0 is control, 8 to 15 are descriptors |
| reg_wdata | input | 32 | Register write data |
| ctl_rdata | output | 12 | Control word read-back |
| evt_trig | input | 1 | External event trigger pulse |
| meas_start | output | 1 | Conversion request pulse |
| meas_tx | output | 4 | TX index of the request |
| meas_rx | output | 4 | RX index of the request |
| meas_done | input | 1 | Conversion finished |
| meas_result | input | 12 | Conversion value |
| res_valid | output | 1 | Result strobe |
| res_desc | output | 3 | Descriptor of the result |
| res_tx | output | 4 | TX index of the result |
| res_rx | output | 4 | RX index of the result |
| res_data | output | 12 | Result value |
| res_over | output | 1 | Value above threshold |
| busy | output | 1 | Pass in progress |
| desc_done | output | 8 | Per-descriptor done flags |

## Verification
The bench compares the order of the pairs under both loop nestings. A swapped or inverted order bit shows up as a transposed sequence. Reversed ranges are also covered, where a naive counter would wrap through all sixteen indices. The threshold test uses one value equal to the threshold, so a greater-or-equal compare sets the flag on that result. The bench also sends an abort and a disable while a slow conversion is outstanding. A design that dropped the pending abort, forwarded the stale result, or left the descriptor or the pass without waiting for the done signal would produce extra results, wrong done flags or an early drop of busy. Reserved trigger codes, triggers while busy and writes to a locked table each have checks as well, and a design that acted on any of them would start unexpected measurements.

// File: rtl/tscan_pkg.sv
// Shared types for the capacitive scan sequencer.
// Assumes 4-bit electrode indices and 12-bit conversion values.
package tscan_pkg;
    localparam int IDX_W = 4;
    localparam int RES_W = 12;

    // One descriptor; packed so {word[31:4], word[0]} maps onto it directly.
    typedef struct packed {
        logic [RES_W-1:0] thresh;
        logic [IDX_W-1:0] rx_last;
        logic [IDX_W-1:0] rx_first;
        logic [IDX_W-1:0] tx_last;
        logic [IDX_W-1:0] tx_first;
        logic             en;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);

    typedef enum logic [1:0] {ST_IDLE, ST_SEEK, ST_START, ST_WAIT} scan_st_t;
endpackage

// File: rtl/tscan_desc_table.sv
// Descriptor storage. A write lands only when wr_allow is high.
// Assumes wr_sel addresses an existing entry.
module tscan_desc_table
    import tscan_pkg::*;
#(
    parameter int N_DESC = 8,
    localparam int SEL_W = $clog2(N_DESC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_stb,
    input  logic                    wr_allow,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [DESC_W-1:0]       wr_word,
    output desc_t [N_DESC-1:0]      tbl
);
    for (genvar g = 0; g < N_DESC; g++) begin : g_ent
        // Hold one descriptor; load it on an allowed write to its slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tbl[g] <= '0;
            else if (wr_stb && wr_allow && wr_sel == SEL_W'(g))
                tbl[g] <= desc_t'(wr_word);
        end
    end

    // R8
    wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_allow) |=> $stable(tbl));
endmodule

// File: rtl/tscan_pick.sv
// Finds the lowest enabled descriptor whose index is at or above 'from'.
// Purely combinational; 'from' may equal N_DESC, meaning none is left.
module tscan_pick #(
    parameter int N_DESC = 8,
    localparam int SEL_W = $clog2(N_DESC),
    localparam int FROM_W = SEL_W + 1
) (
    input  logic [N_DESC-1:0] en_mask,
    input  logic [FROM_W-1:0] from,
    output logic              found,
    output logic [SEL_W-1:0]  idx
);
    // Scan downward so that the lowest qualifying entry wins last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_DESC - 1; i >= 0; i--) begin
            if (en_mask[i] && (FROM_W'(i) >= from)) begin
                found = 1'b1;
                idx   = SEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/tscan_engine.sv
// Scan state machine: walks the enabled descriptors and issues one
// conversion at a time, in the loop order latched at trigger acceptance.
// Assumes meas_done arrives only after a meas_start has been issued.
module tscan_engine
    import tscan_pkg::*;
#(
    parameter int N_DESC = 8,
    localparam int SEL_W = $clog2(N_DESC),
    localparam int PTR_W = SEL_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    arm,
    input  logic                    order,
    input  logic                    trig,
    input  logic                    abort_req,
    input  desc_t [N_DESC-1:0]      tbl,
    output logic                    abort_ack,
    output logic                    busy,
    output logic                    meas_start,
    output logic [IDX_W-1:0]        meas_tx,
    output logic [IDX_W-1:0]        meas_rx,
    input  logic                    meas_done,
    input  logic [RES_W-1:0]        meas_result,
    output logic                    res_valid,
    output logic [SEL_W-1:0]        res_desc,
    output logic [IDX_W-1:0]        res_tx,
    output logic [IDX_W-1:0]        res_rx,
    output logic [RES_W-1:0]        res_data,
    output logic                    res_over,
    output logic [N_DESC-1:0]       desc_done
);
    scan_st_t           st;
    logic [PTR_W-1:0]   ptr;
    logic [SEL_W-1:0]   cur;
    logic               order_q;
    logic [IDX_W-1:0]   tx, rx, tx_b, tx_e, rx_b, rx_e;
    logic [RES_W-1:0]   thr_q;
    logic [N_DESC-1:0]  en_mask;
    logic               pick_found;
    logic [SEL_W-1:0]   pick_idx;
    logic               last_tx, last_rx;
    desc_t              nxt;

    for (genvar g = 0; g < N_DESC; g++) begin : g_mask
        assign en_mask[g] = tbl[g].en;
    end

    tscan_pick #(.N_DESC(N_DESC)) pick_i (
        .en_mask (en_mask),
        .from    (ptr),
        .found   (pick_found),
        .idx     (pick_idx)
    );

    // Decode end-of-range conditions and the next descriptor's fields.
    always_comb begin
        nxt     = tbl[pick_idx];
        last_tx = (tx == tx_e);
        last_rx = (rx == rx_e);
    end

    assign busy       = (st != ST_IDLE);
    assign meas_start = (st == ST_START) && arm && !abort_req;
    assign meas_tx    = tx;
    assign meas_rx    = rx;
    assign abort_ack  = abort_req && arm &&
                        ((st == ST_START) || (st == ST_WAIT && meas_done));

    // Sequence the pass: pick descriptor, request, wait, advance indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;  ptr <= '0;  cur <= '0;  order_q <= 1'b0;
            tx <= '0;  rx <= '0;  tx_b <= '0;  tx_e <= '0;
            rx_b <= '0;  rx_e <= '0;  thr_q <= '0;
            res_valid <= 1'b0;  res_desc <= '0;  res_tx <= '0;  res_rx <= '0;
            res_data <= '0;  res_over <= 1'b0;  desc_done <= '0;
        end else begin
            res_valid <= 1'b0;
            unique case (st)
                ST_IDLE: if (arm && trig) begin
                    st <= ST_SEEK;  ptr <= '0;  desc_done <= '0;  order_q <= order;
                end
                ST_SEEK: begin
                    if (!arm || !pick_found)
                        st <= ST_IDLE;
                    else begin
                        cur   <= pick_idx;
                        ptr   <= PTR_W'(pick_idx) + PTR_W'(1);
                        tx    <= nxt.tx_first;
                        rx    <= nxt.rx_first;
                        tx_b  <= nxt.tx_first;
                        rx_b  <= nxt.rx_first;
                        tx_e  <= (nxt.tx_last < nxt.tx_first) ? nxt.tx_first : nxt.tx_last;
                        rx_e  <= (nxt.rx_last < nxt.rx_first) ? nxt.rx_first : nxt.rx_last;
                        thr_q <= nxt.thresh;
                        st    <= ST_START;
                    end
                end
                ST_START: begin
                    if (!arm)
                        st <= ST_IDLE;
                    else if (abort_req) begin
                        desc_done[cur] <= 1'b1;  st <= ST_SEEK;
                    end else
                        st <= ST_WAIT;
                end
                ST_WAIT: if (meas_done) begin
                    if (!arm)
                        st <= ST_IDLE;
                    else if (abort_req) begin
                        desc_done[cur] <= 1'b1;  st <= ST_SEEK;
                    end else begin
                        res_valid <= 1'b1;  res_desc <= cur;  res_tx <= tx;  res_rx <= rx;
                        res_data  <= meas_result;
                        res_over  <= (meas_result > thr_q);
                        if (last_tx && last_rx) begin
                            desc_done[cur] <= 1'b1;  st <= ST_SEEK;
                        end else begin
                            st <= ST_START;
                            if (order_q) begin
                                if (!last_tx) tx <= tx + 1'b1;
                                else begin tx <= tx_b;  rx <= rx + 1'b1; end
                            end else begin
                                if (!last_rx) rx <= rx + 1'b1;
                                else begin rx <= rx_b;  tx <= tx + 1'b1; end
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R14
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start |=> !meas_start);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!meas_start && !res_valid));
    // R12
    done_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(arm && trig)) |=> $stable(desc_done));
endmodule

// File: rtl/tscan_top.sv
// Capacitive scan sequencer top: control word, trigger selection,
// descriptor table and scan engine.
// Assumes N_DESC is at most 8, so descriptors fit at addresses 8 to 15.
module tscan_top
    import tscan_pkg::*;
#(
    parameter int N_DESC = 8,
    localparam int SEL_W = $clog2(N_DESC),
    localparam int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [11:0]         ctl_rdata,
    input  logic                evt_trig,
    output logic                meas_start,
    output logic [IDX_W-1:0]    meas_tx,
    output logic [IDX_W-1:0]    meas_rx,
    input  logic                meas_done,
    input  logic [RES_W-1:0]    meas_result,
    output logic                res_valid,
    output logic [SEL_W-1:0]    res_desc,
    output logic [IDX_W-1:0]    res_tx,
    output logic [IDX_W-1:0]    res_rx,
    output logic [RES_W-1:0]    res_data,
    output logic                res_over,
    output logic                busy,
    output logic [N_DESC-1:0]   desc_done
);
    logic        en_q, order_q, dwen_q, abort_q, swtrig_q;
    logic [3:0]  tsel_q;
    logic        trig, abort_ack, ctl_wr, desc_wr;
    desc_t [N_DESC-1:0] tbl;

    assign ctl_wr  = reg_wr && (reg_addr == '0);
    assign desc_wr = reg_wr && reg_addr[ADDR_W-1];

    // Control word; abort and software trigger are cleared by hardware.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;  order_q <= 1'b0;  dwen_q <= 1'b0;
            abort_q <= 1'b0;  swtrig_q <= 1'b0;  tsel_q <= '0;
        end else begin
            swtrig_q <= ctl_wr ? reg_wdata[4] : 1'b0;
            if (ctl_wr) begin
                en_q    <= reg_wdata[0];
                order_q <= reg_wdata[1];
                dwen_q  <= reg_wdata[2];
                abort_q <= reg_wdata[3];
                tsel_q  <= reg_wdata[11:8];
            end else if (abort_ack || !busy)
                abort_q <= 1'b0;
        end
    end

    // Route the selected trigger source; reserved codes give none.
    always_comb begin
        unique case (tsel_q)
            4'd0:    trig = swtrig_q;
            4'd1:    trig = evt_trig;
            default: trig = 1'b0;
        endcase
    end

    assign ctl_rdata = {tsel_q, 3'b000, swtrig_q, abort_q, dwen_q, order_q, en_q};

    tscan_desc_table #(.N_DESC(N_DESC)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (desc_wr),
        .wr_allow (dwen_q),
        .wr_sel   (reg_addr[SEL_W-1:0]),
        .wr_word  ({reg_wdata[31:4], reg_wdata[0]}),
        .tbl      (tbl)
    );

    tscan_engine #(.N_DESC(N_DESC)) engine_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (en_q),
        .order       (order_q),
        .trig        (trig),
        .abort_req   (abort_q),
        .tbl         (tbl),
        .abort_ack   (abort_ack),
        .busy        (busy),
        .meas_start  (meas_start),
        .meas_tx     (meas_tx),
        .meas_rx     (meas_rx),
        .meas_done   (meas_done),
        .meas_result (meas_result),
        .res_valid   (res_valid),
        .res_desc    (res_desc),
        .res_tx      (res_tx),
        .res_rx      (res_rx),
        .res_data    (res_data),
        .res_over    (res_over),
        .desc_done   (desc_done)
    );

    // R2
    reserved_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && tsel_q > 4'd1) |=> !busy);
endmodule

// File: tb/tscan_top_tb_top.sv
module tscan_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [11:0] ctl_rdata;
    logic        evt_trig = 1'b0;
    logic        meas_start, meas_done = 1'b0;
    logic [3:0]  meas_tx, meas_rx;
    logic [11:0] meas_result = '0;
    logic        res_valid, res_over, busy;
    logic [2:0]  res_desc;
    logic [3:0]  res_tx, res_rx;
    logic [11:0] res_data;
    logic [7:0]  desc_done;

    int n_chk = 0, n_err = 0, cap_n = 0, starts_n = 0, lat = 2;
    logic [31:0] cap [64];
    logic        cap_ov [64];
    bit          ended = 1'b0;

    always #10 clk = ~clk;

    tscan_top dut_i (.*);

    function automatic logic [11:0] fval(input logic [3:0] t, input logic [3:0] r);
        return 12'(t * 16 + r + 100);
    endfunction
    function automatic logic [31:0] dw(input bit en, input int txf, txl, rxf, rxl, thr);
        return {12'(thr), 4'(rxl), 4'(rxf), 4'(txl), 4'(txf), 3'b000, en};
    endfunction
    function automatic logic [31:0] cw(input bit en, ord, dwen, ab, sw, input int sel);
        return {20'd0, 4'(sel), 3'b000, sw, ab, dwen, ord, en};
    endfunction
    function automatic logic [31:0] pk(input int d, t, r);
        return {9'd0, 3'(d), 4'(t), 4'(r), fval(4'(t), 4'(r))};
    endfunction

    // Measurement unit model: answers each request after 'lat' cycles.
    initial begin
        forever begin
            @(negedge clk);
            while (meas_start) begin
                automatic logic [3:0] t = meas_tx;
                automatic logic [3:0] r = meas_rx;
                starts_n++;
                repeat (lat) @(negedge clk);
                meas_result = fval(t, r);
                meas_done = 1'b1;
                @(negedge clk);
                meas_done = 1'b0;
            end
        end
    end

    // Result capture.
    always @(negedge clk) begin
        if (res_valid && cap_n < 64) begin
            cap[cap_n]    = {9'd0, res_desc, res_tx, res_rx, res_data};
            cap_ov[cap_n] = res_over;
            cap_n++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;  reg_addr = a;  reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic clr_cap();
        cap_n = 0;  starts_n = 0;
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy && k < 3000) begin @(negedge clk); k++; end
        chk("R1 pass ends", 32'(busy), 32'd0);
    endtask

    task automatic pulse_evt();
        @(negedge clk); evt_trig = 1'b1;
        @(negedge clk); evt_trig = 1'b0;
    endtask

    // Software trigger run; checks the self-clear and busy rise.
    task automatic sw_run(input bit ord);
        wr(4'd0, cw(1, ord, 1, 0, 1, 0));
        chk("R3 swtrig set", 32'(ctl_rdata[4]), 32'd1);
        @(negedge clk);
        chk("R3 swtrig cleared", 32'(ctl_rdata[4]), 32'd0);
        chk("R1 busy on accept", 32'(busy), 32'd1);
        wait_idle();
    endtask

    task automatic t_reset();
        chk("R1 reset busy", 32'(busy), 32'd0);
        chk("R1 reset ctl", 32'(ctl_rdata), 32'd0);
        chk("R1 reset done", 32'(desc_done), 32'd0);
        chk("R1 reset outputs", {30'd0, meas_start, res_valid}, 32'd0);
    endtask

    task automatic t_locked();
        clr_cap();
        wr(4'd8, dw(1, 1, 2, 3, 4, 120));
        wr(4'd0, cw(1, 0, 0, 0, 0, 0));
        repeat (20) @(negedge clk);
        chk("R1 armed no scan", 32'(starts_n), 32'd0);
        wr(4'd0, cw(1, 0, 0, 0, 1, 0));
        repeat (3) @(negedge clk);
        wait_idle();
        chk("R8 locked write no results", 32'(cap_n), 32'd0);
        chk("R8 locked write no starts", 32'(starts_n), 32'd0);
    endtask

    task automatic t_order0();
        clr_cap();
        wr(4'd0, cw(0, 0, 1, 0, 0, 0));
        wr(4'd8, dw(1, 1, 2, 3, 4, 120));
        sw_run(0);
        chk("R4 count", 32'(cap_n), 32'd4);
        chk("R4 pair0", cap[0], pk(0, 1, 3));
        chk("R4 pair1", cap[1], pk(0, 1, 4));
        chk("R4 pair2", cap[2], pk(0, 2, 3));
        chk("R4 pair3", cap[3], pk(0, 2, 4));
        chk("R13 over flags", {28'd0, cap_ov[3], cap_ov[2], cap_ov[1], cap_ov[0]}, 32'hC);
        chk("R12 done flags", 32'(desc_done), 32'h01);
    endtask

    task automatic t_order1();
        clr_cap();
        sw_run(1);
        chk("R5 count", 32'(cap_n), 32'd4);
        chk("R5 pair0", cap[0], pk(0, 1, 3));
        chk("R5 pair1", cap[1], pk(0, 2, 3));
        chk("R5 pair2", cap[2], pk(0, 1, 4));
        chk("R5 pair3", cap[3], pk(0, 2, 4));
    endtask

    task automatic t_skip();
        clr_cap();
        wr(4'd8,  dw(0, 1, 2, 3, 4, 0));
        wr(4'd9,  dw(1, 5, 2, 7, 7, 0));
        wr(4'd11, dw(1, 3, 3, 9, 8, 0));
        sw_run(0);
        chk("R6 R7 count", 32'(cap_n), 32'd2);
        chk("R6 reversed tx", cap[0], pk(1, 5, 7));
        chk("R7 R6 reversed rx", cap[1], pk(3, 3, 9));
        chk("R12 done skip", 32'(desc_done), 32'h0A);
    endtask

    task automatic t_trigsel();
        clr_cap();
        wr(4'd0, cw(1, 0, 1, 0, 1, 2));
        pulse_evt();
        repeat (10) @(negedge clk);
        chk("R2 reserved code", {31'd0, busy} + 32'(starts_n), 32'd0);
        wr(4'd0, cw(1, 0, 1, 0, 1, 1));
        repeat (10) @(negedge clk);
        chk("R2 event sel ignores sw", 32'(starts_n), 32'd0);
        pulse_evt();
        chk("R2 event starts pass", 32'(busy), 32'd1);
        repeat (3) @(negedge clk);
        pulse_evt();
        wait_idle();
        chk("R11 retrigger ignored", 32'(cap_n), 32'd2);
        chk("R11 starts", 32'(starts_n), 32'd2);
    endtask

    task automatic t_abort();
        wr(4'd0, cw(0, 0, 1, 0, 0, 0));
        wr(4'd8,  dw(1, 0, 1, 0, 1, 0));
        wr(4'd9,  dw(0, 0, 0, 0, 0, 0));
        wr(4'd11, dw(0, 0, 0, 0, 0, 0));
        wr(4'd10, dw(1, 6, 6, 2, 2, 0));
        clr_cap();
        lat = 30;
        wr(4'd0, cw(1, 0, 1, 0, 1, 0));
        repeat (6) @(negedge clk);
        wr(4'd0, cw(1, 0, 1, 1, 0, 0));
        chk("R9 abort pending", 32'(ctl_rdata[3]), 32'd1);
        wait_idle();
        chk("R9 only next descriptor", 32'(cap_n), 32'd1);
        chk("R9 next result", cap[0], pk(2, 6, 2));
        chk("R9 R12 done flags", 32'(desc_done), 32'h05);
        chk("R9 abort cleared", 32'(ctl_rdata[3]), 32'd0);
        chk("R14 one request per conversion", 32'(starts_n), 32'd2);
    endtask

    task automatic t_disable();
        clr_cap();
        lat = 20;
        wr(4'd0, cw(1, 0, 1, 0, 1, 0));
        repeat (4) @(negedge clk);
        wr(4'd0, cw(0, 0, 1, 0, 0, 0));
        @(negedge clk);
        chk("R10 busy while outstanding", 32'(busy), 32'd1);
        wait_idle();
        chk("R10 no result", 32'(cap_n), 32'd0);
        chk("R10 single request", 32'(starts_n), 32'd1);
        lat = 2;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked();
        t_order0();
        t_order1();
        t_skip();
        t_trigsel();
        t_abort();
        t_disable();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;  n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end
endmodule